// File: doc/BRIEF.md
# Infrared Pulse-Width Capture Controller

This block watches the demodulated output of an infrared receiver and records how long each mark and each space lasts. A programmable divider turns the system clock into a sampling tick. The raw line passes through a two-flop synchronizer, an optional inversion and a glitch filter. The filtered level is then timed in whole ticks. Each duration is stored as one saturating byte in a bank of 32-bit capture words. Four bytes share a word, and the earliest byte sits in the lowest lane.

A message begins at the first accepted mark after a restart. It ends when a space runs long enough to saturate its byte, which leaves 0xFF as the closing entry. The block then waits a programmable number of further ticks before it flags completion. If the bank fills first, the message is cut short and completion is flagged at once. After completion the capture is frozen. Software reads the bank, acknowledges the interrupt and writes the restart bit to arm the block again.

Top module: `ir_pulse_capture`

## Requirements
- R1: After reset, `irq` is low, every capture word reads 0, and the configuration, period, threshold and interrupt-enable registers read 0.
- R2: The sampling tick fires once every (period+1) clocks, with the period in bits 15:0 at 0x10, and only while bit 0 of the configuration register (0x0C) is 1. With that bit at 0, no capture takes place.
- R3: The line is synchronized through two flops. A new level is accepted only after it has been seen on the number of consecutive ticks given in bits 12:8 at 0x14, where 0 counts as 1. A shorter blip does not split the current entry.
- R4: When bit 1 at 0x0C is 1, a low line is a mark. When it is 0, a high line is a mark.
- R5: After a restart the first entry is always a mark, and the entries after it alternate space, mark, and so on. Entry i sits in word i/4, at byte address 0x30+4*(i/4), in bits 8*(i%4)+7 down to 8*(i%4).
- R6: Each entry counts ticks, starting at 1 on the tick whose edge is accepted. A mark entry saturates at 0xFF.
- R7: A space that reaches 255 ticks is stored as 0xFF and ends the message. Completion follows on the (N+1)-th tick after that, where N is the count in bits 23:16 at 0x0C.
- R8: When the 68th entry is stored, completion is flagged on the same tick.
- R9: From completion until a restart, line activity does not change the capture bank.
- R10: Writing 1 to bit 0 at 0x18 zeroes every capture word and waits for a new mark. This write takes priority over capture in the same cycle.
- R11: `irq` is the pending completion flag gated by bit 0 at 0x1C. Writing 1 to bit 0 at 0x20 clears the pending flag. If a new completion arrives in the same cycle, the completion wins.
- R12: Reads of the capture words return the packed bytes. Writes to them have no effect.
- R13: Capture advances only while bit 13 at 0x0C is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | 1 | Demodulated receiver line, asynchronous |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Completion interrupt, level |

## Verification
The bench keeps the default build: 17 capture words, a 16-bit period field and 8-bit addresses. It programs a period of 1 (one tick every two clocks), a filter depth of 2 and a settle count of 3. With those values, a saturated 255-tick space, a mark longer than 255 ticks and a bank overrun of more than 68 edges each take only a few hundred clocks. A single-tick blip falls just below the filter depth, so the glitch path is exercised as well.

// File: rtl/ir_cap_pkg.sv
package ir_cap_pkg;

  localparam int ENTRY_W  = 8;
  localparam int LANES    = 4;
  localparam int DG_W     = 5;
  localparam int SETTLE_W = 8;
  localparam logic [ENTRY_W-1:0] ENTRY_MAX = 8'hFF;

  localparam logic [7:0] OFF_CFG     = 8'h0C;
  localparam logic [7:0] OFF_PERIOD  = 8'h10;
  localparam logic [7:0] OFF_THR     = 8'h14;
  localparam logic [7:0] OFF_RESTART = 8'h18;
  localparam logic [7:0] OFF_IEN     = 8'h1C;
  localparam logic [7:0] OFF_ACK     = 8'h20;
  localparam logic [7:0] OFF_BANK    = 8'h30;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_SETTLE, ST_DONE} cap_state_t;

  // saturating one-tick increment of a width entry
  function automatic logic [ENTRY_W-1:0] width_step(input logic [ENTRY_W-1:0] w);
    return (w == ENTRY_MAX) ? w : w + 1'b1;
  endfunction

  // a differing level is taken once it has been seen on 'need' ticks (0 acts as 1)
  function automatic logic level_taken(input logic [DG_W-1:0] seen, input logic [DG_W-1:0] need);
    logic [DG_W:0] seen_now;
    logic [DG_W:0] need_eff;
    seen_now = {1'b0, seen} + 1'b1;
    need_eff = (need == '0) ? {{DG_W{1'b0}}, 1'b1} : {1'b0, need};
    return seen_now >= need_eff;
  endfunction

endpackage

// File: rtl/ir_cap_sampler.sv
module ir_cap_sampler
  import ir_cap_pkg::*;
#(
  parameter int PERIOD_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                ir_in,
  input  logic                sample_en,
  input  logic                active_low,
  input  logic [PERIOD_W-1:0] period,
  input  logic [DG_W-1:0]     dg_need,
  output logic                tick,
  output logic                accept,
  output logic                level
);

  logic [1:0]          sync_q;
  logic [PERIOD_W-1:0] tcnt_q;
  logic [DG_W-1:0]     seen_q;
  logic                lvl_q;
  logic                mark_now;
  logic                differs;

  assign mark_now = sync_q[1] ^ active_low;
  assign differs  = mark_now != lvl_q;
  assign tick     = sample_en && (tcnt_q >= period);
  assign accept   = tick && differs && level_taken(seen_q, dg_need);
  assign level    = lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      tcnt_q <= '0;
      seen_q <= '0;
      lvl_q  <= 1'b0;
    end else begin
      sync_q <= {sync_q[0], ir_in};
      if (!sample_en || tick) tcnt_q <= '0;
      else                    tcnt_q <= tcnt_q + 1'b1;
      if (tick) begin
        if (accept) begin
          lvl_q  <= mark_now;
          seen_q <= '0;
        end else if (differs) begin
          seen_q <= seen_q + 1'b1;
        end else begin
          seen_q <= '0;
        end
      end
    end
  end

endmodule

// File: rtl/ir_cap_engine.sv
module ir_cap_engine
  import ir_cap_pkg::*;
#(
  parameter int BANK_WORDS = 17,
  localparam int N_ENT = BANK_WORDS * LANES,
  localparam int IDX_W = $clog2(N_ENT + 1)
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          step,
  input  logic                          accept,
  input  logic                          level,
  input  logic                          restart,
  input  logic [SETTLE_W-1:0]           settle_need,
  output logic [BANK_WORDS*32-1:0]      bank_flat,
  output cap_state_t                    state,
  output logic [IDX_W-1:0]              entry_idx,
  output logic                          done_set
);

  cap_state_t           st_q, st_d;
  logic [ENTRY_W-1:0]   width_q, width_d;
  logic [IDX_W-1:0]     idx_q, idx_d;
  logic [SETTLE_W-1:0]  settle_q, settle_d;
  logic                 store_en;
  logic [ENTRY_W-1:0]   store_val;

  assign state     = st_q;
  assign entry_idx = idx_q;

  always_comb begin
    st_d      = st_q;
    width_d   = width_q;
    idx_d     = idx_q;
    settle_d  = settle_q;
    store_en  = 1'b0;
    store_val = width_q;
    done_set  = 1'b0;
    if (restart) begin
      st_d     = ST_IDLE;
      width_d  = '0;
      idx_d    = '0;
      settle_d = '0;
    end else if (step) begin
      unique case (st_q)
        ST_IDLE: begin
          if (accept && !level) begin
            st_d    = ST_RUN;
            width_d = 8'd1;
            idx_d   = '0;
          end
        end
        ST_RUN: begin
          if (accept) begin
            store_en = 1'b1;
            idx_d    = idx_q + 1'b1;
            width_d  = 8'd1;
            if (idx_q == IDX_W'(N_ENT - 1)) begin
              st_d     = ST_DONE;
              done_set = 1'b1;
            end
          end else if (!level && width_q == ENTRY_MAX - 1'b1) begin
            store_en  = 1'b1;
            store_val = ENTRY_MAX;
            idx_d     = idx_q + 1'b1;
            width_d   = '0;
            settle_d  = '0;
            st_d      = ST_SETTLE;
          end else begin
            width_d = width_step(width_q);
          end
        end
        ST_SETTLE: begin
          if (settle_q == settle_need) begin
            st_d     = ST_DONE;
            done_set = 1'b1;
          end else begin
            settle_d = settle_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      width_q  <= '0;
      idx_q    <= '0;
      settle_q <= '0;
    end else begin
      st_q     <= st_d;
      width_q  <= width_d;
      idx_q    <= idx_d;
      settle_q <= settle_d;
    end
  end

  for (genvar g = 0; g < N_ENT; g++) begin : g_ent
    logic [ENTRY_W-1:0] ent_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  ent_q <= '0;
      else if (restart)                            ent_q <= '0;
      else if (store_en && idx_q == IDX_W'(g))     ent_q <= store_val;
    end
    assign bank_flat[g*ENTRY_W +: ENTRY_W] = ent_q;
  end

endmodule

// File: rtl/ir_cap_regs.sv
module ir_cap_regs
  import ir_cap_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PERIOD_W   = 16,
  parameter int PERIOD_RST = 0,
  parameter int BANK_WORDS = 17
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     we,
  input  logic [ADDR_W-1:0]        addr,
  input  logic [31:0]              wdata,
  output logic [31:0]              rdata,
  input  logic [BANK_WORDS*32-1:0] bank_flat,
  input  logic                     done_set,
  output logic                     ir_en,
  output logic                     active_low,
  output logic                     pw_en,
  output logic [SETTLE_W-1:0]      settle_need,
  output logic [PERIOD_W-1:0]      period,
  output logic [DG_W-1:0]          dg_need,
  output logic                     restart,
  output logic                     ack,
  output logic                     irq
);

  logic ien_q, pend_q;
  logic [ADDR_W-1:0] rel;
  logic in_bank;
  logic unused_hi;

  assign unused_hi = ^wdata[31:24];
  assign restart   = we && addr == ADDR_W'(OFF_RESTART) && wdata[0];
  assign ack       = we && addr == ADDR_W'(OFF_ACK) && wdata[0];
  assign irq       = pend_q & ien_q;
  assign rel       = addr - ADDR_W'(OFF_BANK);
  assign in_bank   = int'(addr) >= int'(OFF_BANK) && int'(addr) < int'(OFF_BANK) + 4 * BANK_WORDS;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ir_en       <= 1'b0;
      active_low  <= 1'b0;
      pw_en       <= 1'b0;
      settle_need <= '0;
      period      <= PERIOD_W'(PERIOD_RST);
      dg_need     <= '0;
      ien_q       <= 1'b0;
      pend_q      <= 1'b0;
    end else begin
      if (we && addr == ADDR_W'(OFF_CFG)) begin
        ir_en       <= wdata[0];
        active_low  <= wdata[1];
        pw_en       <= wdata[13];
        settle_need <= wdata[23:16];
      end
      if (we && addr == ADDR_W'(OFF_PERIOD)) period  <= wdata[PERIOD_W-1:0];
      if (we && addr == ADDR_W'(OFF_THR))    dg_need <= wdata[12:8];
      if (we && addr == ADDR_W'(OFF_IEN))    ien_q   <= wdata[0];
      if (done_set) pend_q <= 1'b1;
      else if (ack) pend_q <= 1'b0;
    end
  end

  always_comb begin
    rdata = '0;
    if (addr == ADDR_W'(OFF_CFG))
      rdata = {8'b0, settle_need, 2'b0, pw_en, 11'b0, active_low, ir_en};
    else if (addr == ADDR_W'(OFF_PERIOD))
      rdata = 32'(period);
    else if (addr == ADDR_W'(OFF_THR))
      rdata = {19'b0, dg_need, 8'b0};
    else if (addr == ADDR_W'(OFF_IEN))
      rdata = {31'b0, ien_q};
    else if (in_bank) begin
      for (int w = 0; w < BANK_WORDS; w++)
        if (int'(rel[ADDR_W-1:2]) == w) rdata = bank_flat[w*32 +: 32];
    end
  end

endmodule

// File: rtl/ir_pulse_capture.sv
module ir_pulse_capture
  import ir_cap_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int PERIOD_W   = 16,
  parameter int PERIOD_RST = 0,
  parameter int BANK_WORDS = 17
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ir_in,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq
);

  localparam int IDX_W = $clog2(BANK_WORDS * LANES + 1);

  logic                     ir_en, active_low, pw_en;
  logic [SETTLE_W-1:0]      settle_need;
  logic [PERIOD_W-1:0]      period;
  logic [DG_W-1:0]          dg_need;
  logic                     tick_w, accept_w, level_w;
  logic                     restart_w, ack_w, done_set_w;
  cap_state_t               cap_state_w;
  logic [IDX_W-1:0]         cap_idx_w;
  logic [BANK_WORDS*32-1:0] bank_w;

  ir_cap_sampler #(.PERIOD_W(PERIOD_W)) u_sampler (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in),
    .sample_en(ir_en), .active_low(active_low),
    .period(period), .dg_need(dg_need),
    .tick(tick_w), .accept(accept_w), .level(level_w)
  );

  ir_cap_engine #(.BANK_WORDS(BANK_WORDS)) u_engine (
    .clk(clk), .rst_n(rst_n),
    .step(tick_w & pw_en), .accept(accept_w), .level(level_w),
    .restart(restart_w), .settle_need(settle_need),
    .bank_flat(bank_w), .state(cap_state_w), .entry_idx(cap_idx_w),
    .done_set(done_set_w)
  );

  ir_cap_regs #(
    .ADDR_W(ADDR_W), .PERIOD_W(PERIOD_W),
    .PERIOD_RST(PERIOD_RST), .BANK_WORDS(BANK_WORDS)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .we(reg_we), .addr(reg_addr), .wdata(reg_wdata), .rdata(reg_rdata),
    .bank_flat(bank_w), .done_set(done_set_w),
    .ir_en(ir_en), .active_low(active_low), .pw_en(pw_en),
    .settle_need(settle_need), .period(period), .dg_need(dg_need),
    .restart(restart_w), .ack(ack_w), .irq(irq)
  );

endmodule

// File: rtl/ir_pulse_capture_checker.sv
module ir_pulse_capture_checker
  import ir_cap_pkg::*;
#(
  parameter int BANK_WORDS = 17,
  localparam int N_ENT = BANK_WORDS * LANES,
  localparam int IDX_W = $clog2(N_ENT + 1)
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     irq,
  input logic                     tick_w,
  input logic                     accept_w,
  input logic                     level_w,
  input logic                     restart_w,
  input logic                     ack_w,
  input logic                     done_set_w,
  input cap_state_t               cap_state_w,
  input logic [IDX_W-1:0]         cap_idx_w,
  input logic [BANK_WORDS*32-1:0] bank_w
);

  assert_accept_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    accept_w |-> tick_w);

  assert_idx_in_bank_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cap_idx_w <= IDX_W'(N_ENT));

  assert_first_is_mark_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_state_w == ST_RUN && $past(cap_state_w) == ST_IDLE) |-> (cap_idx_w == '0 && level_w));

  assert_restart_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    restart_w |=> (bank_w == '0 && cap_state_w == ST_IDLE));

  assert_frozen_when_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_state_w == ST_DONE && !restart_w) |=> $stable(bank_w));

  assert_ack_drops_irq_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_w && !done_set_w) |=> !irq);

endmodule

bind ir_pulse_capture ir_pulse_capture_checker #(.BANK_WORDS(BANK_WORDS)) u_chk (.*);

// File: tb/ir_pulse_capture_tb.sv
module ir_pulse_capture_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ir_in = 1'b0;
  logic        reg_we = 1'b0;
  logic [7:0]  reg_addr = 8'h30;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        irq;

  int checks = 0;
  int fails  = 0;
  string cur_req = "R1";
  bit cmp_on = 1'b0;
  bit mk = 1'b1;

  always #10 clk = ~clk;

  ir_pulse_capture u_dut (
    .clk(clk), .rst_n(rst_n), .ir_in(ir_in),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  // ---------------- behavioural reference ----------------
  int m_s1, m_s2, m_tcnt, m_lvl, m_seen, m_state, m_width, m_settle, m_pend;
  int m_en, m_pol, m_pw, m_need_settle, m_period, m_thr, m_ien;
  int caps[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = 0; m_s2 = 0; m_tcnt = 0; m_lvl = 0; m_seen = 0;
      m_state = 0; m_width = 0; m_settle = 0; m_pend = 0;
      m_en = 0; m_pol = 0; m_pw = 0; m_need_settle = 0; m_period = 0; m_thr = 0; m_ien = 0;
      caps.delete();
    end else begin
      int mark, need, was;
      bit tk, acc, dset;
      mark = m_s2 ^ m_pol;
      was  = m_lvl;
      need = (m_thr == 0) ? 1 : m_thr;
      tk   = (m_en != 0) && (m_tcnt >= m_period);
      acc  = tk && (mark != m_lvl) && (m_seen + 1 >= need);
      m_tcnt = (m_en == 0 || tk) ? 0 : m_tcnt + 1;
      if (tk) begin
        if (acc) begin m_lvl = mark; m_seen = 0; end
        else if (mark != m_lvl) m_seen++;
        else m_seen = 0;
      end
      m_s2 = m_s1; m_s1 = int'(ir_in);
      dset = 0;
      if (reg_we && reg_addr == 8'h18 && reg_wdata[0]) begin
        m_state = 0; caps.delete(); m_width = 0; m_settle = 0;
      end else if (tk && m_pw != 0) begin
        case (m_state)
          0: if (acc && was == 0) begin m_state = 1; m_width = 1; end
          1: begin
            if (acc) begin
              caps.push_back(m_width); m_width = 1;
              if (caps.size() == 68) begin m_state = 3; dset = 1; end
            end else if (was == 0 && m_width == 254) begin
              caps.push_back(255); m_width = 0; m_settle = 0; m_state = 2;
            end else if (m_width < 255) m_width++;
          end
          2: if (m_settle == m_need_settle) begin m_state = 3; dset = 1; end
             else m_settle++;
          default: ;
        endcase
      end
      if (dset) m_pend = 1;
      else if (reg_we && reg_addr == 8'h20 && reg_wdata[0]) m_pend = 0;
      if (reg_we) begin
        case (reg_addr)
          8'h0C: begin m_en = int'(reg_wdata[0]); m_pol = int'(reg_wdata[1]);
                       m_pw = int'(reg_wdata[13]); m_need_settle = int'(reg_wdata[23:16]); end
          8'h10: m_period = int'(reg_wdata[15:0]);
          8'h14: m_thr = int'(reg_wdata[12:8]);
          8'h1C: m_ien = int'(reg_wdata[0]);
          default: ;
        endcase
      end
    end
  end

  function automatic int m_entry(int i);
    return (i < caps.size()) ? caps[i] : 0;
  endfunction

  function automatic logic [31:0] m_read(logic [7:0] a);
    int w;
    case (a)
      8'h0C: return 32'(m_en) | (32'(m_pol) << 1) | (32'(m_pw) << 13) | (32'(m_need_settle) << 16);
      8'h10: return 32'(m_period);
      8'h14: return 32'(m_thr) << 8;
      8'h1C: return 32'(m_ien);
      default: begin
        if (a >= 8'h30 && a < 8'h74) begin
          w = (int'(a) - 'h30) / 4;
          return 32'(m_entry(4*w) | (m_entry(4*w+1) << 8) | (m_entry(4*w+2) << 16) | (m_entry(4*w+3) << 24));
        end
        return 32'h0;
      end
    endcase
  endfunction

  // per-clock comparison away from the active edge
  always @(negedge clk) begin
    #2;
    if (rst_n && cmp_on) begin
      logic [31:0] er;
      logic ei;
      er = m_read(reg_addr);
      ei = (m_pend != 0) && (m_ien != 0);
      checks++;
      if (reg_rdata !== er || irq !== ei) begin
        fails++;
        $display("FAIL %s addr=%h rdata=%h expected=%h irq=%b expected=%b",
                 cur_req, reg_addr, reg_rdata, er, irq, ei);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk); reg_addr = a[7:0]; #3; v = int'(reg_rdata);
  endtask

  task automatic entry(int i, output int v);
    int w;
    rd('h30 + 4 * (i / 4), w);
    v = (w >> (8 * (i % 4))) & 255;
  endtask

  task automatic irq_is(string tag, int exp);
    @(negedge clk); #3; chk(tag, int'(irq), exp);
  endtask

  task automatic line(bit v, int ticks);
    ir_in = v;
    repeat (ticks * 2) @(negedge clk);
  endtask

  task automatic send(int k, int mt, int st);
    for (int i = 0; i < k; i++) begin
      line(mk, mt);
      if (i < k - 1) line(!mk, st);
    end
    line(!mk, 300);
  endtask

  task automatic rearm();
    wr(8'h20, 32'h1);
    wr(8'h18, 32'h1);
  endtask

  // ---------------- stimulus ----------------
  task automatic run_tests();
    int v, w0, w1;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    cmp_on = 1'b1;
    cur_req = "R1";
    irq_is("R1 irq after reset", 0);
    rd('h0C, v); chk("R1 config reset", v, 0);
    rd('h10, v); chk("R1 period reset", v, 0);
    rd('h30, v); chk("R1 bank word0 reset", v, 0);

    cur_req = "R2";
    wr(8'h10, 32'd1);
    wr(8'h14, 32'h0000_0200);
    wr(8'h0C, 32'h0003_2001);
    wr(8'h1C, 32'h1);
    rd('h0C, v); chk("R2 config readback", v, 'h0003_2001);

    cur_req = "R5";
    send(3, 10, 6);
    irq_is("R7 completion raised", 1);
    entry(5, v); chk("R7 closing space is FF", v, 255);
    entry(0, v); chk("R6 first mark width near 10", int'(v >= 9 && v <= 11), 1);
    entry(4, v); chk("R5 third mark present", int'(v != 0), 1);
    entry(6, v); chk("R5 nothing past end", v, 0);

    cur_req = "R9";
    rd('h30, w0); rd('h34, w1);
    line(mk, 10); line(!mk, 10); line(mk, 10); line(!mk, 5);
    rd('h30, v); chk("R9 word0 frozen", v, w0);
    rd('h34, v); chk("R9 word1 frozen", v, w1);

    cur_req = "R11";
    wr(8'h20, 32'h1);
    irq_is("R11 ack clears irq", 0);

    cur_req = "R12";
    wr(8'h30, 32'hFFFF_FFFF);
    rd('h30, v); chk("R12 capture write ignored", v, w0);

    cur_req = "R10";
    wr(8'h18, 32'h1);
    for (int i = 0; i < 17; i++) begin
      rd('h30 + 4 * i, v); chk("R10 bank cleared", v, 0);
    end

    cur_req = "R3";
    wr(8'h1C, 32'h0);
    line(mk, 10); line(!mk, 5); line(mk, 1); line(!mk, 5); line(mk, 10); line(!mk, 300);
    irq_is("R11 masked irq stays low", 0);
    entry(3, v); chk("R3 glitch did not add entries", v, 255);
    entry(1, v); chk("R3 space spans the blip", int'(v >= 10 && v <= 12), 1);
    wr(8'h1C, 32'h1);
    irq_is("R11 unmask shows pending", 1);
    rearm();

    cur_req = "R6";
    send(1, 300, 0);
    entry(0, v); chk("R6 long mark saturates", v, 255);
    entry(1, v); chk("R7 end marker after saturated mark", v, 255);
    rearm();

    cur_req = "R8";
    for (int i = 0; i < 36; i++) begin line(mk, 4); line(!mk, 4); end
    irq_is("R8 full bank completes", 1);
    entry(67, v); chk("R8 last entry is a short space", int'(v >= 3 && v <= 5), 1);
    rearm();

    cur_req = "R4";
    wr(8'h0C, 32'h0003_0003);
    ir_in = 1'b1;
    repeat (40) @(negedge clk);
    wr(8'h0C, 32'h0003_2003);
    wr(8'h18, 32'h1);
    mk = 1'b0;
    send(2, 8, 8);
    irq_is("R4 active-low message completes", 1);
    entry(0, v); chk("R4 low level timed as mark", int'(v >= 7 && v <= 9), 1);
    entry(3, v); chk("R4 end marker", v, 255);
    rearm();

    cur_req = "R2";
    wr(8'h0C, 32'h0003_2002);
    wr(8'h18, 32'h1);
    send(2, 8, 8);
    rd('h30, v); chk("R2 disabled sampler captures nothing", v, 0);
    irq_is("R2 no completion when disabled", 0);

    cur_req = "R13";
    wr(8'h0C, 32'h0003_0003);
    wr(8'h18, 32'h1);
    send(2, 8, 8);
    rd('h30, v); chk("R13 width detection off captures nothing", v, 0);
    irq_is("R13 no completion when detection off", 0);
  endtask

  initial begin
    fork
      run_tests();
      begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule